// File: doc/BRIEF.md
# Serial Word Transmitter with Wrap Path

This block turns a stream of 10-bit pre-encoded words into a serial bit stream that runs on a single bit-rate clock. An internal modulo-ten counter produces the byte strobe. On the clock edge that closes a strobe cycle the block captures one word from the parallel input. It then sends that word's bits out one per clock, starting with bit 0. A fixed pipeline stands between the shift register and the serial pins, and it sets the delay from capture to the first bit on the line.

A wrap control chooses where the stream goes. With wrap low, the stream drives the external serial output, and the receive-side bit output passes the external serial input through. With wrap high, the external output sits at a constant 0 and the stream feeds the receive-side bit output, so the receiver sees its own transmitter without any medium. The control is sampled together with each word. A change therefore reaches the pins on the first bit of the next word and never splits one.

Top module: `wrapSerializer`

## Requirements
- R1: `byteStb` is high for exactly one clock in every ten, first in the tenth clock after reset is released.
- R2: `txWord` is captured only on the rising edge that ends a cycle in which `byteStb` is high. Its value at any other edge has no effect on the outputs.
- R3: The bits of a captured word leave in the order bit 0, bit 1, … bit 9, one per clock, with no gap between consecutive words.
- R4: Bit 0 of a word appears on the serial path `LATENCY` clocks (default 8) after the edge that captured it.
- R5: For a word captured with `loopEn` low, `serOut` carries that word's bits and `rxSerBit` equals `extSerIn`.
- R6: For a word captured with `loopEn` high, `serOut` is held at 0 and `rxSerBit` carries that word's bits.
- R7: `loopEn` is sampled only at the capture edge. A change at any other time takes effect at the next word boundary on the serial path.
- R8: During and right after reset, `serOut` is 0, `byteStb` is 0 and `rxSerBit` equals `extSerIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txWord | input | 10 | Pre-encoded word, bit 0 sent first |
| loopEn | input | 1 | Wrap control, 1 routes the stream to the receive side |
| extSerIn | input | 1 | External serial input for the receiver |
| serOut | output | 1 | External serial output, 0 while wrapped |
| rxSerBit | output | 1 | Serial bit selected for the receiver |
| byteStb | output | 1 | High in the cycle whose closing edge captures `txWord` |

## Verification
Random words with `loopEn` held low exercise the external path. Meanwhile `extSerIn` toggles at random, which shows that the receive mux passes the pin through and does not leak the stream. A second run holds `loopEn` high and includes the words 0x001, 0x200, 0x3FF and 0x17C. These words separate a correct bit order from a reversed order and a correct latency from one that is off by a clock. A third run flips `loopEn` at random clocks inside words, which shows whether the mode switch waits for a word boundary or tears a word apart. Because `txWord` changes on every clock, any capture away from the strobe also shows up as a mismatch.

// File: rtl/wrapSerPkg.sv
package wrapSerPkg;
  // strobes handed from control to datapath
  typedef struct packed {
    logic load;  // capture txWord at this edge
    logic wrap;  // wrap control to store with the captured word
  } serCtlT;
endpackage

// File: rtl/wrapSerCtrl.sv
module wrapSerCtrl
  import wrapSerPkg::*;
#(
  parameter int WORD_BITS = 10
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   loopEn,
  output serCtlT ctl
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (bitCnt == LAST) bitCnt <= '0;
    else                    bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    ctl.load = (bitCnt == LAST);
    ctl.wrap = loopEn;
  end

  // R1
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> !ctl.load);

  // R1
  strobe_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (bitCnt == '0));
endmodule

// File: rtl/wrapSerData.sv
module wrapSerData
  import wrapSerPkg::*;
#(
  parameter int WORD_BITS = 10,
  parameter int LATENCY   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  serCtlT               ctl,
  input  logic [WORD_BITS-1:0] txWord,
  input  logic                 extSerIn,
  output logic                 serOut,
  output logic                 rxSerBit
);
  logic [WORD_BITS-1:0] shiftReg;
  logic                 modeReg;
  logic [LATENCY-1:0]   pipeBit;
  logic [LATENCY-1:0]   pipeMode;
  logic                 lineBit;
  logic                 lineMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      modeReg  <= 1'b0;
    end else if (ctl.load) begin
      shiftReg <= txWord;
      modeReg  <= ctl.wrap;
    end else begin
      shiftReg <= {1'b0, shiftReg[WORD_BITS-1:1]};
    end
  end

  genvar i;
  generate
    for (i = 0; i < LATENCY; i++) begin : gStage
      if (i == 0) begin : gHead
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            pipeBit[0]  <= 1'b0;
            pipeMode[0] <= 1'b0;
          end else begin
            pipeBit[0]  <= shiftReg[0];
            pipeMode[0] <= modeReg;
          end
        end
      end else begin : gTail
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            pipeBit[i]  <= 1'b0;
            pipeMode[i] <= 1'b0;
          end else begin
            pipeBit[i]  <= pipeBit[i-1];
            pipeMode[i] <= pipeMode[i-1];
          end
        end
      end
    end
  endgenerate

  assign lineBit  = pipeBit[LATENCY-1];
  assign lineMode = pipeMode[LATENCY-1];

  always_comb begin
    serOut   = lineMode ? 1'b0 : lineBit;
    rxSerBit = lineMode ? lineBit : extSerIn;
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (shiftReg == $past(txWord)));

  // R3
  shift_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> (shiftReg[WORD_BITS-2:0] == $past(shiftReg[WORD_BITS-1:1])));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(modeReg));

  // R6
  wrap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineMode |-> (serOut == 1'b0));
endmodule

// File: rtl/wrapSerializer.sv
module wrapSerializer
  import wrapSerPkg::*;
#(
  parameter int WORD_BITS = 10,
  parameter int LATENCY   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] txWord,
  input  logic                 loopEn,
  input  logic                 extSerIn,
  output logic                 serOut,
  output logic                 rxSerBit,
  output logic                 byteStb
);
  serCtlT ctl;

  wrapSerCtrl #(.WORD_BITS(WORD_BITS)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .loopEn (loopEn),
    .ctl    (ctl)
  );

  wrapSerData #(.WORD_BITS(WORD_BITS), .LATENCY(LATENCY)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .txWord   (txWord),
    .extSerIn (extSerIn),
    .serOut   (serOut),
    .rxSerBit (rxSerBit)
  );

  assign byteStb = ctl.load;
endmodule

// File: tb/sim_wrapSerializer.sv
module sim_wrapSerializer;
  localparam int W = 10;
  localparam int L = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] txWord = '0;
  logic         loopEn = 1'b0;
  logic         extSerIn = 1'b1;
  logic         serOut, rxSerBit, byteStb;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wrapSerializer #(.WORD_BITS(W), .LATENCY(L)) u0 (
    .clk(clk), .rstN(rstN), .txWord(txWord), .loopEn(loopEn),
    .extSerIn(extSerIn), .serOut(serOut), .rxSerBit(rxSerBit), .byteStb(byteStb)
  );

  // behavioural reference: word counter, current word, queue of line bits
  int       mCnt = 0;
  int       mWord = 0;
  bit       mMode = 0;
  bit       qBit[$];
  bit       qMode[$];
  bit       expBit = 0;
  bit       expMode = 0;

  initial begin
    for (int k = 0; k < L; k++) begin qBit.push_back(0); qMode.push_back(0); end
  end

  always @(posedge clk) begin
    if (rstN) begin
      bit ld;
      ld = (mCnt == W - 1);
      mCnt = ld ? 0 : mCnt + 1;
      if (ld) begin       // R2 R7: word and mode taken only here
        mWord = int'(txWord);
        mMode = loopEn;
      end else begin
        mWord = mWord >> 1;  // R3: next bit up moves to the line
      end
      qBit.push_back(bit'(mWord & 1));
      qMode.push_back(mMode);
      expBit  = qBit.pop_front();   // R4: L edges of delay
      expMode = qMode.pop_front();
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        // R8
        total++;
        if (serOut !== 1'b0 || byteStb !== 1'b0 || rxSerBit !== extSerIn) begin
          bad++;
          $display("FAIL R8 reset act=%b%b%b exp=0%b0", serOut, rxSerBit, byteStb, extSerIn);
        end
      end else begin
        bit es, er, eb;
        eb = (mCnt == W - 1);
        es = expMode ? 1'b0 : expBit;
        er = expMode ? expBit : extSerIn;
        total++;
        if (byteStb !== eb) begin
          bad++;
          $display("FAIL R1 byteStb act=%b exp=%b", byteStb, eb);
        end
        total++;
        if (serOut !== es) begin
          bad++;
          if (expMode) $display("FAIL R6 R7 serOut act=%b exp=%b", serOut, es);
          else $display("FAIL R2 R3 R4 R5 serOut act=%b exp=%b", serOut, es);
        end
        total++;
        if (rxSerBit !== er) begin
          bad++;
          if (expMode) $display("FAIL R2 R3 R4 R6 rxSerBit act=%b exp=%b", rxSerBit, er);
          else $display("FAIL R5 R7 rxSerBit act=%b exp=%b", rxSerBit, er);
        end
      end
    end
  end

  task automatic step(input int n, input int loopMode);
    // loopMode: 0 low, 1 high, 2 random each clock
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      txWord   = W'($urandom);          // R2: changes every clock
      extSerIn = 1'($urandom);
      if (loopMode == 2) loopEn = 1'($urandom);
      else loopEn = (loopMode == 1);
    end
  endtask

  task automatic directedWord(input logic [W-1:0] w);
    // wait until the strobe cycle, then present w for that capture only
    do begin @(posedge clk); #2; txWord = W'($urandom); end while (!byteStb);
    txWord = w;
    @(posedge clk); #2; txWord = ~w;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    @(posedge clk); #2; rstN = 1'b1;
    step(300, 0);                 // R5 external path
    step(300, 1);                 // R6 wrap path
    loopEn = 1'b1;
    directedWord(10'h001);        // R3 R4 single set bit at the start
    directedWord(10'h200);        // R3 single set bit at the end
    directedWord(10'h3FF);
    directedWord(10'h17C);
    step(30, 1);
    step(400, 2);                 // R7 mid-word toggles
    step(200, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    done = 1;
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule